// File: doc/BRIEF.md
# ADC Output Word Formatter

This block sits between a 12-bit converter core and the output pins. On every sample strobe it takes the raw offset-binary sample and its overflow flag, applies the selected coding, and registers the result as the output word. The word has one overflow bit and a data field. The codings are plain offset binary, two's complement, and alternate-bit polarity. A built-in pattern source can replace the live data so that the digital interface can be tested on the board. The pattern source offers constant ones, constant zeros, an alternating word and a checkerboard word.

All mode controls are plain inputs. The block samples them together with the data on a strobe cycle, so a mode change applies from the next valid sample. Each output bit, and the clock-out driver, has its own registered enable, and an output-disable control clears all of these enables. A scrambler enable is accepted but passes the data through unchanged.

Top module: `adc_word_fmt`

## Requirements
- R1: While rst_n is low, out_data is 0, out_ovf is 0, every bit of out_oe is 0 and clkout_oe is 0.
- R2: With cfg_pat_en, cfg_alt_pol and cfg_twos all low, a cycle with smp_valid high gives out_data = smp_data and out_ovf = smp_ovf one clock later (offset binary).
- R3: With cfg_pat_en and cfg_alt_pol low and cfg_twos high, the registered word is smp_data with its most significant bit inverted. out_ovf equals smp_ovf.
- R4: With cfg_pat_en low and cfg_alt_pol high, out_data is smp_data with every odd-numbered bit (1, 3, 5, …) inverted, whatever the value of cfg_twos. out_ovf equals smp_ovf.
- R5: cfg_scr_en changes no output in any mode.
- R6: With cfg_pat_en high, cfg_pat_sel = 2'b00 gives all ones and 2'b01 gives all zeros. In both cases the value covers out_ovf as well as out_data.
- R7: cfg_pat_sel = 2'b10 gives an alternating pattern. The first valid sample after the pattern is entered (pattern was off on the previous valid sample, or had a different select) gives all ones. Each later valid sample gives the complement of the previous word.
- R8: cfg_pat_sel = 2'b11 gives a checkerboard. Its first word after entry is out_ovf = 1 with the even data bits 1 and the odd data bits 0 (data 0x555). Each later valid sample gives the complement (out_ovf = 0, data 0xAAA).
- R9: While cfg_pat_en is high, the pattern output is unaffected by cfg_twos, cfg_alt_pol, cfg_scr_en, smp_data and smp_ovf.
- R10: In a cycle with smp_valid low, out_data and out_ovf hold their values, and the pattern phase does not advance.
- R11: One clock after cfg_out_dis is sampled high, all out_oe bits and clkout_oe are 0. One clock after it is sampled low, they are all 1. This happens on every clock, whatever the state of smp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe from the converter core |
| smp_data | input | 12 | Raw offset-binary sample |
| smp_ovf | input | 1 | Overflow flag for the sample |
| cfg_twos | input | 1 | Select two's-complement coding |
| cfg_alt_pol | input | 1 | Select alternate-bit-polarity coding |
| cfg_scr_en | input | 1 | Scrambler enable (data pass-through) |
| cfg_pat_en | input | 1 | Replace live data with a test pattern |
| cfg_pat_sel | input | 2 | Pattern select: 00 ones, 01 zeros, 10 alternating, 11 checkerboard |
| cfg_out_dis | input | 1 | Put every output in the high-impedance state |
| out_data | output | 12 | Registered data word |
| out_ovf | output | 1 | Registered overflow bit |
| out_oe | output | 13 | Per-bit enables, bit 12 for overflow, bits 11..0 for data |
| clkout_oe | output | 1 | Enable for the clock-out driver |

## Verification
Two events can arrive in the same strobe cycle: a change of pattern mode or select, and the advance of the pattern phase. The block must treat such a cycle as an entry and restart from the first word, not toggle the old phase. The stimulus provokes this with directed switches between alternating and checkerboard on back-to-back strobes and with strobe gaps in between. Random stimulus also flips the pattern controls during live traffic. A bench model tracks the last sampled mode and the phase, and it predicts each word on its own. Output-disable edges are also placed on strobe cycles and on idle cycles, and the enables are checked one clock later in each case.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;

  // Test pattern selection, encoded as on cfg_pat_sel
  typedef enum logic [1:0] {
    PAT_ONES  = 2'b00,
    PAT_ZEROS = 2'b01,
    PAT_ALT   = 2'b10,
    PAT_CHECK = 2'b11
  } pat_sel_e;

endpackage

// File: rtl/adcfmt_code.sv
// Live-data coding: offset binary, two's complement, alternate-bit polarity
module adcfmt_code #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              twos,
  input  logic              alt_pol,
  input  logic              scr_en,
  output logic [DATA_W-1:0] coded
);

  localparam int MSB = DATA_W - 1;

  // Scrambler is a pass-through stage in this model
  logic              scr_unused;
  logic [DATA_W-1:0] scr_out;
  assign scr_unused = scr_en;
  assign scr_out    = raw;

  // Alternate polarity forces offset binary and ignores the two's-complement bit
  logic use_twos;
  assign use_twos = twos & ~alt_pol;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if ((i % 2) == 1 && i == MSB) begin : g_odd_msb
      assign coded[i] = scr_out[i] ^ (alt_pol | use_twos);
    end else if ((i % 2) == 1) begin : g_odd
      assign coded[i] = scr_out[i] ^ alt_pol;
    end else if (i == MSB) begin : g_even_msb
      assign coded[i] = scr_out[i] ^ use_twos;
    end else begin : g_pass
      assign coded[i] = scr_out[i];
    end
  end

endmodule

// File: rtl/adcfmt_patgen.sv
// Test pattern source with a phase that advances on valid samples
module adcfmt_patgen
  import adcfmt_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic            pat_en,
  input  logic [1:0]      pat_sel,
  output logic [DATA_W:0] pat_word
);

  localparam int WORD_W = DATA_W + 1;

  // Checkerboard first word: top bit (overflow) is 1, then alternating down
  function automatic logic [WORD_W-1:0] check_base();
    logic [WORD_W-1:0] w;
    for (int j = 0; j < WORD_W; j++) begin
      w[j] = (((WORD_W - 1 - j) % 2) == 0);
    end
    return w;
  endfunction

  localparam logic [WORD_W-1:0] CHECK0 = check_base();

  pat_sel_e sel;
  assign sel = pat_sel_e'(pat_sel);

  logic     ph_q, ph_d;
  logic     last_en_q, last_en_d;
  pat_sel_e last_sel_q, last_sel_d;
  logic     entering, cur_ph;

  assign entering = pat_en & (~last_en_q | (last_sel_q != sel));
  assign cur_ph   = entering ? 1'b0 : ph_q;

  always_comb begin
    ph_d       = ph_q;
    last_en_d  = last_en_q;
    last_sel_d = last_sel_q;
    if (smp_valid) begin
      last_en_d  = pat_en;
      last_sel_d = sel;
      if (pat_en) begin
        ph_d = ~cur_ph;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= 1'b0;
      last_en_q  <= 1'b0;
      last_sel_q <= PAT_ONES;
    end else begin
      ph_q       <= ph_d;
      last_en_q  <= last_en_d;
      last_sel_q <= last_sel_d;
    end
  end

  always_comb begin
    unique case (sel)
      PAT_ONES:  pat_word = '1;
      PAT_ZEROS: pat_word = '0;
      PAT_ALT:   pat_word = cur_ph ? '0 : '1;
      PAT_CHECK: pat_word = cur_ph ? ~CHECK0 : CHECK0;
      default:   pat_word = '0;
    endcase
  end

  // R10
  ph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(ph_q));

  // R7
  ph_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && entering) |=> ph_q);

endmodule

// File: rtl/adcfmt_outreg.sv
// Output word register and per-bit output enables
module adcfmt_outreg #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W:0]   word_d,
  input  logic              out_dis,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ovf,
  output logic [DATA_W:0]   out_oe,
  output logic              clkout_oe
);

  logic [DATA_W:0] word_q, word_nx;
  logic [DATA_W:0] oe_q, oe_nx;
  logic            coe_q, coe_nx;

  always_comb begin
    word_nx = word_q;
    if (load) begin
      word_nx = word_d;
    end
    oe_nx  = out_dis ? '0 : '1;
    coe_nx = ~out_dis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      oe_q   <= '0;
      coe_q  <= 1'b0;
    end else begin
      word_q <= word_nx;
      oe_q   <= oe_nx;
      coe_q  <= coe_nx;
    end
  end

  assign out_data  = word_q[DATA_W-1:0];
  assign out_ovf   = word_q[DATA_W];
  assign out_oe    = oe_q;
  assign clkout_oe = coe_q;

  // R11
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_dis |=> (out_oe == '0) && !clkout_oe);

  // R11
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_dis |=> (&out_oe) && clkout_oe);

endmodule

// File: rtl/adc_word_fmt.sv
// Top: converter output word formatting
module adc_word_fmt
  import adcfmt_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_ovf,
  input  logic              cfg_twos,
  input  logic              cfg_alt_pol,
  input  logic              cfg_scr_en,
  input  logic              cfg_pat_en,
  input  logic [1:0]        cfg_pat_sel,
  input  logic              cfg_out_dis,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ovf,
  output logic [DATA_W:0]   out_oe,
  output logic              clkout_oe
);

  function automatic logic [DATA_W-1:0] odd_bits();
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      m[i] = ((i % 2) == 1);
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] ODD_MASK = odd_bits();
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] live_coded;
  logic [DATA_W:0]   pat_word;
  logic [DATA_W:0]   sel_word;

  adcfmt_code #(.DATA_W(DATA_W)) u_code (
    .raw     (smp_data),
    .twos    (cfg_twos),
    .alt_pol (cfg_alt_pol),
    .scr_en  (cfg_scr_en),
    .coded   (live_coded)
  );

  adcfmt_patgen #(.DATA_W(DATA_W)) u_pat (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .pat_en    (cfg_pat_en),
    .pat_sel   (cfg_pat_sel),
    .pat_word  (pat_word)
  );

  // Test patterns win over every live coding
  assign sel_word = cfg_pat_en ? pat_word : {smp_ovf, live_coded};

  adcfmt_outreg #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (smp_valid),
    .word_d    (sel_word),
    .out_dis   (cfg_out_dis),
    .out_data  (out_data),
    .out_ovf   (out_ovf),
    .out_oe    (out_oe),
    .clkout_oe (clkout_oe)
  );

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(out_data) && $stable(out_ovf));

  // R2
  offbin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !cfg_pat_en && !cfg_alt_pol && !cfg_twos)
      |=> (out_data == $past(smp_data)) && (out_ovf == $past(smp_ovf)));

  // R3
  twos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !cfg_pat_en && !cfg_alt_pol && cfg_twos)
      |=> (out_data == ($past(smp_data) ^ MSB_MASK)) && (out_ovf == $past(smp_ovf)));

  // R4
  altpol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !cfg_pat_en && cfg_alt_pol)
      |=> (out_data == ($past(smp_data) ^ ODD_MASK)) && (out_ovf == $past(smp_ovf)));

  // R6
  ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cfg_pat_en && cfg_pat_sel == 2'b00) |=> (&out_data) && out_ovf);

  // R6
  zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cfg_pat_en && cfg_pat_sel == 2'b01) |=> (out_data == '0) && !out_ovf);

  // R8
  check_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cfg_pat_en && cfg_pat_sel == 2'b11)
      |=> (out_data == (out_ovf ? ~ODD_MASK : ODD_MASK)));

endmodule

// File: tb/tb_adc_word_fmt.sv
module tb_adc_word_fmt;
  localparam int W = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          smp_valid, smp_ovf;
  logic [W-1:0]  smp_data;
  logic          cfg_twos, cfg_alt_pol, cfg_scr_en, cfg_pat_en, cfg_out_dis;
  logic [1:0]    cfg_pat_sel;
  logic [W-1:0]  out_data;
  logic          out_ovf, clkout_oe;
  logic [W:0]    out_oe;

  adc_word_fmt #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ovf(smp_ovf), .cfg_twos(cfg_twos), .cfg_alt_pol(cfg_alt_pol),
    .cfg_scr_en(cfg_scr_en), .cfg_pat_en(cfg_pat_en), .cfg_pat_sel(cfg_pat_sel),
    .cfg_out_dis(cfg_out_dis), .out_data(out_data), .out_ovf(out_ovf),
    .out_oe(out_oe), .clkout_oe(clkout_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference model state
  logic [W:0] exp_word = '0;
  string      exp_tag  = "R1";
  logic       m_ph = 1'b0, m_last_en = 1'b0;
  logic [1:0] m_last_sel = 2'b00;

  function automatic logic [W:0] live_fmt(logic [W-1:0] d, logic o, logic tw, logic ap);
    logic [W-1:0] r;
    r = d;
    if (ap) begin
      for (int i = 1; i < W; i += 2) r[i] = ~r[i];
    end else if (tw) begin
      r[W-1] = ~r[W-1];
    end
    return {o, r};
  endfunction

  function automatic logic [W:0] pat_fmt(logic [1:0] s, logic ph);
    logic [W:0] c;
    case (s)
      2'b00: return '1;
      2'b01: return '0;
      2'b10: return ph ? '0 : '1;
      default: begin
        c = {1'b1, {(W/2){2'b01}}};
        return ph ? ~c : c;
      end
    endcase
  endfunction

  task automatic check(string tag, logic [W:0] act, logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle of stimulus, model it, check outputs after the edge
  task automatic cyc(logic v, logic [W-1:0] d, logic o, logic tw, logic ap,
                     logic sc, logic pe, logic [1:0] ps, logic dis);
    logic ent, ph;
    smp_valid = v; smp_data = d; smp_ovf = o; cfg_twos = tw; cfg_alt_pol = ap;
    cfg_scr_en = sc; cfg_pat_en = pe; cfg_pat_sel = ps; cfg_out_dis = dis;
    if (v) begin
      if (pe) begin
        ent = !m_last_en || (m_last_sel != ps);
        ph = ent ? 1'b0 : m_ph;
        exp_word = pat_fmt(ps, ph);
        m_ph = ~ph;
        if (tw || ap || sc) exp_tag = "R9";
        else if (ps[1] == 1'b0) exp_tag = "R6";
        else if (ps == 2'b10) exp_tag = "R7";
        else exp_tag = "R8";
      end else begin
        exp_word = live_fmt(d, o, tw, ap);
        exp_tag = ap ? "R4" : tw ? "R3" : sc ? "R5" : "R2";
      end
      m_last_en = pe;
      m_last_sel = ps;
    end else begin
      exp_tag = "R10";
    end
    @(negedge clk);
    check(exp_tag, {out_ovf, out_data}, exp_word);
    check("R11", {clkout_oe, out_oe[W-1:0]}, dis ? '0 : '1);
    check("R11", {W+1{out_oe[W]}}, dis ? '0 : '1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A7C));
    rst_n = 1'b0;
    smp_valid = 1'b1; smp_data = 12'hABC; smp_ovf = 1'b1; cfg_twos = 1'b0;
    cfg_alt_pol = 1'b0; cfg_scr_en = 1'b0; cfg_pat_en = 1'b1; cfg_pat_sel = 2'b00;
    cfg_out_dis = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {out_ovf, out_data}, '0);
    check("R1", {clkout_oe, out_oe[W-1:0]}, '0);
    check("R1", {W+1{out_oe[W]}}, '0);
    rst_n = 1'b1;

    // R2 offset binary
    cyc(1, 12'h000, 0, 0, 0, 0, 0, 2'b00, 0);
    cyc(1, 12'hFFF, 1, 0, 0, 0, 0, 2'b00, 0);
    cyc(1, 12'h800, 0, 0, 0, 0, 0, 2'b00, 0);
    // R3 two's complement
    cyc(1, 12'h800, 0, 1, 0, 0, 0, 2'b00, 0);
    cyc(1, 12'h7FF, 1, 1, 0, 0, 0, 2'b00, 0);
    // R4 alternate polarity, two's bit ignored
    cyc(1, 12'h000, 0, 1, 1, 0, 0, 2'b00, 0);
    cyc(1, 12'hFFF, 1, 0, 1, 1, 0, 2'b00, 0);
    // R5 scrambler has no effect
    cyc(1, 12'h3C5, 1, 0, 0, 1, 0, 2'b00, 0);
    // R10 hold with no strobe
    cyc(0, 12'h123, 0, 1, 1, 0, 0, 2'b00, 0);
    // R6 ones and zeros, overflow forced
    cyc(1, 12'h000, 0, 0, 0, 0, 1, 2'b00, 0);
    cyc(1, 12'hFFF, 1, 0, 0, 0, 1, 2'b01, 0);
    // R7 alternating with gaps
    cyc(1, 12'h555, 0, 0, 0, 0, 1, 2'b10, 0);
    cyc(1, 12'h555, 0, 0, 0, 0, 1, 2'b10, 0);
    cyc(0, 12'h555, 0, 0, 0, 0, 1, 2'b10, 0);
    cyc(1, 12'h555, 0, 0, 0, 0, 1, 2'b10, 0);
    // R8 switch to checkerboard on a strobe restarts the phase
    cyc(1, 12'h000, 1, 0, 0, 0, 1, 2'b11, 0);
    cyc(1, 12'h000, 1, 0, 0, 0, 1, 2'b11, 0);
    cyc(0, 12'h000, 1, 0, 0, 0, 1, 2'b10, 0);
    cyc(1, 12'h000, 1, 0, 0, 0, 1, 2'b11, 0);
    // R9 pattern overrides codings
    cyc(1, 12'h9A3, 1, 1, 1, 1, 1, 2'b11, 0);
    cyc(1, 12'h9A3, 0, 1, 1, 1, 1, 2'b10, 0);
    // R11 disable on strobe and on idle cycles
    cyc(1, 12'h111, 0, 0, 0, 0, 0, 2'b00, 1);
    cyc(0, 12'h222, 0, 0, 0, 0, 0, 2'b00, 1);
    cyc(0, 12'h333, 0, 0, 0, 0, 0, 2'b00, 0);
    cyc(1, 12'h444, 1, 0, 0, 0, 0, 2'b00, 0);

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic tw, ap, sc, pe, dis;
      logic [1:0] ps;
      tw = ($urandom % 3) == 0;
      ap = ($urandom % 4) == 0;
      sc = ($urandom % 2) == 0;
      pe = ($urandom % 3) == 0;
      ps = 2'($urandom);
      dis = ($urandom % 8) == 0;
      cyc(($urandom % 10) < 7, 12'($urandom), 1'($urandom), tw, ap, sc, pe, ps, dis);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule